// File: doc/BRIEF.md
# Banked 24-bit Address Former

This block turns a 16-bit program counter, a 16- or 24-bit operand, an index value, a direct-page base with an 8-bit offset, or a stack pointer into a 24-bit bus address. The access type chosen by the caller selects how the address is built. Two bank registers supply the upper address byte: one for code and one for data. Both are loaded through write strobes.

Bank handling differs by path. Code fetches stay inside the program bank, so a PC wrap never changes the bank. Indexed data accesses add the index to the full 24-bit bank-and-operand value, so a carry can move that one access into the next bank. The stored data bank does not change. Direct-page and stack accesses always go to bank 0x00. Long accesses take the 24-bit operand as-is.

The address path is purely combinational from the inputs and the stored banks. A bank write takes effect on the cycle after its strobe. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `banked_addr_gen`

## Requirements
- R1: While reset is asserted, bank strobes are ignored, and after reset both banks read as 0x00. A fetch then yields {0x00, pc} and an absolute access yields {0x00, operand[15:0]}.
- R2: Access type 1 (fetch) yields {program bank, pc}. With pc = 0xFFFF the upper byte is still the program bank.
- R3: Access type 2 (absolute) yields {data bank, operand[15:0]}.
- R4: Access type 3 (indexed) yields ({data bank, operand[15:0]} + index) mod 2^24. A carry past bit 15 raises the upper byte for that access only, and the stored data bank is unchanged.
- R5: The index adds its full 16 bits when idx_narrow = 0. When idx_narrow = 1 it adds only index[7:0], zero-extended.
- R6: Access type 4 (long) yields operand[23:0]. The data bank has no effect.
- R7: Access type 5 (direct) yields {0x00, (dp + offset) mod 2^16}.
- R8: Access type 6 (stack) yields {0x00, sp}.
- R9: prog_valid is 1 only for type 1. data_valid is 1 only for types 2 to 6. Types 0 and 7 are idle: both qualifiers are 0 and the address is 0.
- R10: dp_extra is 1 exactly when the access is type 5 and dp[7:0] is nonzero.
- R11: db_we or pb_we loads bank_wdata into the data or program bank at a clock edge. The new value is seen from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_type | input | 3 | Access type code |
| pc | input | 16 | Program counter |
| operand | input | 24 | Instruction operand (16 or 24 bits used) |
| dir_ofs | input | 8 | Direct-page offset |
| index | input | 16 | X or Y index value |
| idx_narrow | input | 1 | 1: index is 8 bits wide |
| sp | input | 16 | Stack pointer |
| dp | input | 16 | Direct-page base |
| db_we | input | 1 | Load data bank |
| pb_we | input | 1 | Load program bank |
| bank_wdata | input | 8 | Value for bank loads |
| addr | output | 24 | Bus address |
| prog_valid | output | 1 | Address is a code fetch |
| data_valid | output | 1 | Address is a data access |
| dp_extra | output | 1 | Direct page not page-aligned |

## Verification
The bench targets these corner cases:
- Indexed sums that cross 0xFFFF. A design that dropped the carry would stay in the current bank.
- A PC of 0xFFFF. A design that carried into the bank would fetch from the wrong bank.
- A narrow index whose high byte is nonzero. A design that ignored idx_narrow would add extra high bits.
- Direct-page sums that pass 0xFFFF. A design that did not wrap at 16 bits would leak into bank 0x01.

Further checks read back the data bank after an indexed carry to catch a design that wrote the carry into the bank. Strobes asserted during reset catch a bank that loads while reset is held. Randomized accesses mixed with bank writes are compared against a reference model in the bench.

// File: rtl/eag_pkg.sv
package eag_pkg;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned OFS_W  = 16;
  localparam int unsigned BANK_W = ADDR_W - OFS_W;
  localparam int unsigned NBANKS = 2;
  localparam int unsigned BANK_DB = 0;
  localparam int unsigned BANK_PB = 1;

  typedef enum logic [2:0] {
    ACC_IDLE  = 3'd0,
    ACC_FETCH = 3'd1,
    ACC_ABS   = 3'd2,
    ACC_IDX   = 3'd3,
    ACC_LONG  = 3'd4,
    ACC_DIR   = 3'd5,
    ACC_STK   = 3'd6,
    ACC_RSVD  = 3'd7
  } acc_e;
endpackage

// File: rtl/eag_rst_sync.sv
module eag_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/eag_bank_reg.sv
module eag_bank_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] val_q;
  logic [W-1:0] val_d;

  always_comb begin
    val_d = val_q;
    if (we) val_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign q = val_q;
endmodule

// File: rtl/eag_addr_path.sv
module eag_addr_path
  import eag_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned OW = OFS_W
) (
  input  logic [2:0]     acc_type,
  input  logic [OW-1:0]  pc,
  input  logic [AW-1:0]  operand,
  input  logic [7:0]     dir_ofs,
  input  logic [OW-1:0]  index,
  input  logic           idx_narrow,
  input  logic [OW-1:0]  sp,
  input  logic [OW-1:0]  dp,
  input  logic [AW-OW-1:0] db,
  input  logic [AW-OW-1:0] pb,
  output logic [AW-1:0]  addr,
  output logic           prog_valid,
  output logic           data_valid,
  output logic           dp_extra
);
  localparam int unsigned BW = AW - OW;

  logic [OW-1:0] idx_eff;
  logic [AW-1:0] idx_sum;
  logic [OW-1:0] dir_sum;
  acc_e          kind;

  always_comb begin
    kind = acc_e'(acc_type);
    if (idx_narrow) idx_eff = {{(OW-8){1'b0}}, index[7:0]};
    else            idx_eff = index;
    idx_sum = {db, operand[OW-1:0]} + {{BW{1'b0}}, idx_eff};
    dir_sum = dp + {{(OW-8){1'b0}}, dir_ofs};
  end

  always_comb begin
    addr       = '0;
    prog_valid = 1'b0;
    data_valid = 1'b0;
    dp_extra   = 1'b0;
    unique case (kind)
      ACC_FETCH: begin
        addr       = {pb, pc};
        prog_valid = 1'b1;
      end
      ACC_ABS: begin
        addr       = {db, operand[OW-1:0]};
        data_valid = 1'b1;
      end
      ACC_IDX: begin
        addr       = idx_sum;
        data_valid = 1'b1;
      end
      ACC_LONG: begin
        addr       = operand;
        data_valid = 1'b1;
      end
      ACC_DIR: begin
        addr       = {{BW{1'b0}}, dir_sum};
        data_valid = 1'b1;
        dp_extra   = (dp[7:0] != 8'h00);
      end
      ACC_STK: begin
        addr       = {{BW{1'b0}}, sp};
        data_valid = 1'b1;
      end
      default: begin
        addr = '0;
      end
    endcase
  end
endmodule

// File: rtl/banked_addr_gen.sv
module banked_addr_gen
  import eag_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  acc_type,
  input  logic [15:0] pc,
  input  logic [23:0] operand,
  input  logic [7:0]  dir_ofs,
  input  logic [15:0] index,
  input  logic        idx_narrow,
  input  logic [15:0] sp,
  input  logic [15:0] dp,
  input  logic        db_we,
  input  logic        pb_we,
  input  logic [7:0]  bank_wdata,
  output logic [23:0] addr,
  output logic        prog_valid,
  output logic        data_valid,
  output logic        dp_extra
);
  logic                rst_q_n;
  logic [NBANKS-1:0]   bank_we;
  logic [BANK_W-1:0]   bank_q [NBANKS];
  logic [BANK_W-1:0]   db_q;
  logic [BANK_W-1:0]   pb_q;

  eag_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  always_comb begin
    bank_we          = '0;
    bank_we[BANK_DB] = db_we;
    bank_we[BANK_PB] = pb_we;
  end

  for (genvar g = 0; g < NBANKS; g++) begin : g_bank
    eag_bank_reg #(.W(BANK_W)) i_bank (
      .clk   (clk),
      .rst_n (rst_q_n),
      .we    (bank_we[g]),
      .wdata (bank_wdata),
      .q     (bank_q[g])
    );
  end

  assign db_q = bank_q[BANK_DB];
  assign pb_q = bank_q[BANK_PB];

  eag_addr_path #(.AW(ADDR_W), .OW(OFS_W)) i_path (
    .acc_type   (acc_type),
    .pc         (pc),
    .operand    (operand),
    .dir_ofs    (dir_ofs),
    .index      (index),
    .idx_narrow (idx_narrow),
    .sp         (sp),
    .dp         (dp),
    .db         (db_q),
    .pb         (pb_q),
    .addr       (addr),
    .prog_valid (prog_valid),
    .data_valid (data_valid),
    .dp_extra   (dp_extra)
  );
endmodule

// File: rtl/eag_checker.sv
module eag_checker (
  input logic        clk,
  input logic        rst_q_n,
  input logic [2:0]  acc_type,
  input logic [15:0] pc,
  input logic [23:0] operand,
  input logic [15:0] sp,
  input logic [15:0] dp,
  input logic        pb_we,
  input logic        db_we,
  input logic [7:0]  bank_wdata,
  input logic [7:0]  pb_q,
  input logic [7:0]  db_q,
  input logic [23:0] addr,
  input logic        prog_valid,
  input logic        data_valid,
  input logic        dp_extra
);
  // R2: fetch address keeps pc in the low half and the program bank on top
  p_fetch_bank_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (acc_type == 3'd1) |-> (addr == {pb_q, pc}));

  // R6: long access passes the operand through
  p_long_pass_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (acc_type == 3'd4) |-> (addr == operand));

  // R7, R8: direct page and stack stay in bank 0
  p_bank_zero_r7: assert property (@(posedge clk) disable iff (!rst_q_n)
    (acc_type == 3'd5) |-> (addr[23:16] == 8'h00));
  p_stack_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (acc_type == 3'd6) |-> (addr == {8'h00, sp}));

  // R9: qualifiers never both high
  p_qual_excl_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({prog_valid, data_valid}));

  // R10: extra-cycle flag only for an unaligned direct page
  p_dpx_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    dp_extra |-> (dp[7:0] != 8'h00 && acc_type == 3'd5));

  // R11: banks hold without a strobe and load with one
  p_pb_hold_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    !pb_we |=> $stable(pb_q));
  p_db_load_r11: assert property (@(posedge clk) disable iff (!rst_q_n)
    db_we |=> (db_q == $past(bank_wdata)));
endmodule

bind banked_addr_gen eag_checker i_eag_checker (
  .clk        (clk),
  .rst_q_n    (rst_q_n),
  .acc_type   (acc_type),
  .pc         (pc),
  .operand    (operand),
  .sp         (sp),
  .dp         (dp),
  .pb_we      (pb_we),
  .db_we      (db_we),
  .bank_wdata (bank_wdata),
  .pb_q       (pb_q),
  .db_q       (db_q),
  .addr       (addr),
  .prog_valid (prog_valid),
  .data_valid (data_valid),
  .dp_extra   (dp_extra)
);

// File: tb/test_banked_addr_gen.sv
module test_banked_addr_gen;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned NVEC = 11;
  localparam int unsigned NRAND = 300;

  typedef struct packed {
    logic [2:0]  acc;
    logic [15:0] pc;
    logic [23:0] op;
    logic [7:0]  ofs;
    logic [15:0] idx;
    logic        xn;
    logic [15:0] sp;
    logic [15:0] dp;
    logic [23:0] ea;
    logic        pv;
    logic        dv;
    logic        dx;
  } vec_t;

  // banks loaded before the table: data bank 0x12, program bank 0x34
  localparam vec_t VEC [NVEC] = '{
    '{3'd1, 16'hABCD, 24'h0, 8'h0, 16'h0, 1'b0, 16'h0, 16'h0, 24'h34ABCD, 1'b1, 1'b0, 1'b0},
    '{3'd1, 16'hFFFF, 24'h0, 8'h0, 16'h0, 1'b0, 16'h0, 16'h0, 24'h34FFFF, 1'b1, 1'b0, 1'b0},
    '{3'd2, 16'h0, 24'h995678, 8'h0, 16'h0, 1'b0, 16'h0, 16'h0, 24'h125678, 1'b0, 1'b1, 1'b0},
    '{3'd3, 16'h0, 24'h00FFF0, 8'h0, 16'h0020, 1'b0, 16'h0, 16'h0, 24'h130010, 1'b0, 1'b1, 1'b0},
    '{3'd3, 16'h0, 24'h00FF00, 8'h0, 16'h12F0, 1'b1, 16'h0, 16'h0, 24'h12FFF0, 1'b0, 1'b1, 1'b0},
    '{3'd4, 16'h0, 24'hABCDEF, 8'h0, 16'h0, 1'b0, 16'h0, 16'h0, 24'hABCDEF, 1'b0, 1'b1, 1'b0},
    '{3'd5, 16'h0, 24'h0, 8'h34, 16'h0, 1'b0, 16'h0, 16'h1200, 24'h001234, 1'b0, 1'b1, 1'b0},
    '{3'd5, 16'h0, 24'h0, 8'h20, 16'h0, 1'b0, 16'h0, 16'hFFF1, 24'h000011, 1'b0, 1'b1, 1'b1},
    '{3'd6, 16'h0, 24'h0, 8'h0, 16'h0, 1'b0, 16'h01FF, 16'h0, 24'h0001FF, 1'b0, 1'b1, 1'b0},
    '{3'd0, 16'h1111, 24'h222222, 8'h0, 16'h0, 1'b0, 16'h0, 16'h0, 24'h000000, 1'b0, 1'b0, 1'b0},
    '{3'd3, 16'h0, 24'h00FFFF, 8'h0, 16'hFFFF, 1'b0, 16'h0, 16'h0, 24'h13FFFE, 1'b0, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  acc_type;
  logic [15:0] pc, index, sp, dp;
  logic [23:0] operand;
  logic [7:0]  dir_ofs, bank_wdata;
  logic        idx_narrow, db_we, pb_we;
  logic [23:0] addr;
  logic        prog_valid, data_valid, dp_extra;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] m_db, m_pb;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_addr_gen i_banked_addr_gen (
    .clk(clk), .rst_n(rst_n), .acc_type(acc_type), .pc(pc), .operand(operand),
    .dir_ofs(dir_ofs), .index(index), .idx_narrow(idx_narrow), .sp(sp), .dp(dp),
    .db_we(db_we), .pb_we(pb_we), .bank_wdata(bank_wdata), .addr(addr),
    .prog_valid(prog_valid), .data_valid(data_valid), .dp_extra(dp_extra)
  );

  function automatic logic [26:0] model(input logic [2:0] a, input logic [15:0] p,
      input logic [23:0] o, input logic [7:0] f, input logic [15:0] ix,
      input logic xn, input logic [15:0] s, input logic [15:0] d,
      input logic [7:0] bd, input logic [7:0] bp);
    logic [23:0] e;
    logic [15:0] ie;
    logic pv, dv, dx;
    ie = xn ? {8'h00, ix[7:0]} : ix;
    pv = 1'b0; dv = 1'b1; dx = 1'b0;
    case (a)
      3'd1: begin e = {bp, p}; pv = 1'b1; dv = 1'b0; end
      3'd2: e = {bd, o[15:0]};
      3'd3: e = {bd, o[15:0]} + {8'h00, ie};
      3'd4: e = o;
      3'd5: begin e = {8'h00, d + {8'h00, f}}; dx = (d[7:0] != 0); end
      3'd6: e = {8'h00, s};
      default: begin e = 24'h0; dv = 1'b0; end
    endcase
    return {e, pv, dv, dx};
  endfunction

  task automatic check(input string req, input logic [26:0] act, input logic [26:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: addr/pv/dv/dx actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] a, input logic [15:0] p, input logic [23:0] o,
      input logic [7:0] f, input logic [15:0] ix, input logic xn,
      input logic [15:0] s, input logic [15:0] d);
    acc_type = a; pc = p; operand = o; dir_ofs = f; index = ix;
    idx_narrow = xn; sp = s; dp = d;
  endtask

  task automatic wr_bank(input logic sel_pb, input logic [7:0] v);
    @(negedge clk);
    bank_wdata = v; db_we = !sel_pb; pb_we = sel_pb;
    @(negedge clk);
    db_we = 1'b0; pb_we = 1'b0;
    if (sel_pb) m_pb = v; else m_db = v;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; db_we = 1'b0; pb_we = 1'b0; bank_wdata = 8'h00;
    drive(3'd0, 16'h0, 24'h0, 8'h0, 16'h0, 1'b0, 16'h0, 16'h0);
    m_db = 8'h00; m_pb = 8'h00;
    // R1: strobes during reset are ignored
    repeat (2) @(negedge clk);
    bank_wdata = 8'h5A; db_we = 1'b1; pb_we = 1'b1;
    repeat (2) @(negedge clk);
    db_we = 1'b0; pb_we = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(3'd1, 16'h4321, 24'h0, 8'h0, 16'h0, 1'b0, 16'h0, 16'h0);
    #1 check("R1 fetch after reset", {addr, prog_valid, data_valid, dp_extra}, {24'h004321, 3'b100});
    drive(3'd2, 16'h0, 24'hFF8765, 8'h0, 16'h0, 1'b0, 16'h0, 16'h0);
    #1 check("R1 absolute after reset", {addr, prog_valid, data_valid, dp_extra}, {24'h008765, 3'b010});

    // R11: bank loads, seen on the next cycle
    wr_bank(1'b0, 8'h12);
    wr_bank(1'b1, 8'h34);
    drive(3'd2, 16'h0, 24'h00AAAA, 8'h0, 16'h0, 1'b0, 16'h0, 16'h0);
    #1 check("R11 data bank load", {addr, prog_valid, data_valid, dp_extra}, {24'h12AAAA, 3'b010});

    // Table: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VEC[i].acc, VEC[i].pc, VEC[i].op, VEC[i].ofs, VEC[i].idx, VEC[i].xn, VEC[i].sp, VEC[i].dp);
      #1 check($sformatf("R2-type table vector %0d (R2 R3 R4 R5 R6 R7 R8 R9 R10)", i),
               {addr, prog_valid, data_valid, dp_extra}, {VEC[i].ea, VEC[i].pv, VEC[i].dv, VEC[i].dx});
    end

    // R4: data bank unchanged after an indexed carry
    @(negedge clk);
    drive(3'd2, 16'h0, 24'h000001, 8'h0, 16'h0, 1'b0, 16'h0, 16'h0);
    #1 check("R4 bank unchanged after carry", {addr, prog_valid, data_valid, dp_extra}, {24'h120001, 3'b010});
    // R6: long ignores the data bank
    wr_bank(1'b0, 8'hEE);
    drive(3'd4, 16'h0, 24'h010203, 8'h0, 16'h0, 1'b0, 16'h0, 16'h0);
    #1 check("R6 long ignores bank", {addr, prog_valid, data_valid, dp_extra}, {24'h010203, 3'b010});
    // R9: reserved code 7 idles
    drive(3'd7, 16'hFFFF, 24'hFFFFFF, 8'hFF, 16'hFFFF, 1'b0, 16'hFFFF, 16'hFFFF);
    #1 check("R9 reserved code idle", {addr, prog_valid, data_valid, dp_extra}, 27'h0);
    // R10: aligned direct page, no extra cycle
    drive(3'd5, 16'h0, 24'h0, 8'hFF, 16'h0, 1'b0, 16'h0, 16'hFF00);
    #1 check("R10 aligned direct", {addr, prog_valid, data_valid, dp_extra}, {24'h00FFFF, 3'b010});
    // R5: narrow index high byte ignored
    drive(3'd3, 16'h0, 24'h000010, 8'h0, 16'hFF05, 1'b1, 16'h0, 16'h0);
    #1 check("R5 narrow index", {addr, prog_valid, data_valid, dp_extra}, {24'hEE0015, 3'b010});

    // Randomized accesses with occasional bank writes
    for (int k = 0; k < NRAND; k++) begin
      logic [2:0]  ra;
      logic [15:0] rp, rix, rs, rd;
      logic [23:0] ro;
      logic [7:0]  rf;
      logic        rx;
      if (($urandom % 8) == 0) wr_bank(1'($urandom), 8'($urandom));
      ra = 3'($urandom);
      rp = ($urandom % 4 == 0) ? 16'hFFFF : 16'($urandom);
      ro = ($urandom % 3 == 0) ? {8'($urandom), 8'hFF, 8'($urandom)} : 24'($urandom);
      rf = 8'($urandom); rix = 16'($urandom); rx = 1'($urandom);
      rs = 16'($urandom); rd = 16'($urandom);
      if ($urandom % 2 == 0) rd[7:0] = 8'h00;
      @(negedge clk);
      drive(ra, rp, ro, rf, rix, rx, rs, rd);
      #1 check($sformatf("R4 R7 random access %0d", k), {addr, prog_valid, data_valid, dp_extra},
               model(ra, rp, ro, rf, rix, rx, rs, rd, m_db, m_pb));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule